// File: doc/BRIEF.md
# Call, Return and Interrupt Stack Controller

This block moves the flow of control between a running program, its subroutines and its interrupt handlers. It keeps a memory stack through a single-port word memory. On a subroutine call it stores the address of the instruction after the call, advances the stack pointer and hands the processor a new program counter. A plain return reverses these steps. The instruction decoder starts calls and returns with one-cycle strobes. Interrupts are raised by request lines, and the controller takes them only at an instruction boundary.

When the controller takes an interrupt, it stores two words on the stack, the resume address and then the status word. It then loads a vector that depends on the class of the cause: internal fault, external device or software system call. It also clears the interrupt-enable bit in the new status word. A return-from-interrupt restores the status word and then the program counter. If a push would run past the stack's configured depth, or a pop would run below its base, the transfer does not happen. The block instead jumps to the internal-fault vector and touches no memory.

Top module: `cirq_ctl`

## Requirements
- R1: While reset is high and in the cycle after it, `sp` is 0, `busy` is low and none of `mem_we`, `mem_re`, `pc_load`, `psw_load` is asserted.
- R2: In the cycle after an accepted `call_req`, the block writes `next_pc` to memory address `sp` and presents `call_target` on `pc_out` with `pc_load` high. `sp` is one higher in the cycle after that.
- R3: In the cycle after an accepted `ret_req`, the block reads address `sp-1` and decrements `sp`. Memory returns read data one cycle after `mem_re`, and the block presents that word on `pc_out` with `pc_load` high in that cycle.
- R4: Taking an interrupt writes the resume address (`next_pc`) to address `sp` in one cycle, then `psw_in` to address `sp+1` in the next cycle. `sp` ends two higher.
- R5: In the cycle of the second push, `pc_out` carries the class vector with `pc_load` high, and `irq_ack` carries a one-hot flag for the class. The classes, from highest priority: fault (vector 0x0010, `irq_ack` bit 0), external (0x0020, bit 1), software (0x0030, bit 2).
- R6: The status word loaded on interrupt entry (`psw_load` high) equals the saved status with bit 7, interrupt enable, cleared.
- R7: A pending request has no effect unless `at_boundary` is high and bit 7 of `psw_in` is set. Otherwise the block stays idle, with no memory access and no load.
- R8: After an accepted `reti_req`, the block reads `sp-1` and loads the returned word as the status word. It then reads `sp-2` and loads the returned word as the program counter. `sp` ends two lower.
- R9: A call when `sp` equals the depth (16), or an interrupt when fewer than two free words remain, makes no memory write and leaves `sp` unchanged. In the cycle after the strobe or take, `pc_out` is the fault vector and `psw_out` is `psw_in` with bit 7 cleared.
- R10: A return with `sp` at 0, or a return-from-interrupt with `sp` below 2, takes the same fault path as R9, with no memory read.
- R11: In an idle cycle, call, return and return-from-interrupt strobes win over a pending interrupt. `busy` is high while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Subroutine call strobe |
| ret_req | input | 1 | Subroutine return strobe |
| reti_req | input | 1 | Return-from-interrupt strobe |
| call_target | input | DW | Effective address of the called routine |
| next_pc | input | DW | Address of the following instruction (saved as the resume point) |
| at_boundary | input | 1 | High between instructions; interrupts are sampled only then |
| psw_in | input | DW | Current status word, bit 7 = interrupt enable |
| fault_irq | input | 1 | Internal fault request (divide by zero, overflow, protection) |
| ext_irq | input | 1 | External device request |
| swi_irq | input | 1 | Software system-call request |
| mem_rdata | input | DW | Stack memory read data, valid one cycle after `mem_re` |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | SPW | Stack memory word address |
| mem_wdata | output | DW | Stack memory write data |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | DW | New program counter value |
| psw_load | output | 1 | Load `psw_out` into the status word |
| psw_out | output | DW | New status word value |
| irq_ack | output | 3 | One-hot acknowledge of the class taken |
| sp | output | SPW | Stack pointer (next free word) |
| busy | output | 1 | Transfer in progress; strobes are ignored |

## Verification
A wrong stack pointer shows at the ports on the next push or pop. The write or read lands at the wrong `mem_addr`, and a later return hands back a stale or foreign `pc_out`. The bench therefore nests calls to the full depth and unwinds them, checking every address and popped value in order. A wrong priority or mask shows within two cycles of a take, as a wrong vector, wrong `irq_ack` bit or a set enable bit on `psw_out`. A broken limit check shows in the cycle after the strobe, as a write at address 16 or a missing fault vector.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CALL,
        ST_RET_RD,
        ST_RET_WB,
        ST_IRQ_PC,
        ST_IRQ_PSW,
        ST_RTI_PSW,
        ST_RTI_PC,
        ST_RTI_WB,
        ST_FAULT
    } ctl_state_e;

    typedef enum logic [1:0] {
        CL_NONE,
        CL_FAULT,
        CL_EXT,
        CL_SWI
    } irq_class_e;

    typedef struct packed {
        logic fault;
        logic ext;
        logic swi;
    } irq_lines_t;

    // Fixed priority: internal fault, then external, then software.
    function automatic irq_class_e pick_class(irq_lines_t l);
        if (l.fault)    return CL_FAULT;
        else if (l.ext) return CL_EXT;
        else if (l.swi) return CL_SWI;
        return CL_NONE;
    endfunction

    // Acknowledge bits: 0 fault, 1 external, 2 software.
    function automatic logic [2:0] class_ack(irq_class_e c);
        case (c)
            CL_FAULT: return 3'b001;
            CL_EXT:   return 3'b010;
            CL_SWI:   return 3'b100;
            default:  return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/cirq_arb.sv
module cirq_arb
    import cirq_pkg::*;
(
    input  irq_lines_t lines,
    input  logic       enable,
    output logic       take,
    output irq_class_e cls
);
    always_comb begin
        cls  = pick_class(lines);
        take = enable && (cls != CL_NONE);
    end
endmodule

// File: rtl/cirq_sptr.sv
module cirq_sptr #(
    parameter int DEPTH = 16,
    parameter int SPW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           inc,
    input  logic           dec,
    output logic [SPW-1:0] sp,
    output logic           room1,
    output logic           room2,
    output logic           has1,
    output logic           has2
);
    localparam logic [SPW-1:0] TOP = SPW'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst)      sp <= '0;
        else if (inc) sp <= sp + SPW'(1);
        else if (dec) sp <= sp - SPW'(1);
    end

    always_comb begin
        room1 = int'(sp) + 1 <= DEPTH;
        room2 = int'(sp) + 2 <= DEPTH;
        has1  = int'(sp) >= 1;
        has2  = int'(sp) >= 2;
    end

    p_sp_range_r9: assert property (@(posedge clk) disable iff (rst) sp <= TOP);
    p_no_push_full_r9: assert property (@(posedge clk) disable iff (rst) (sp == TOP) |-> !inc);
    p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (rst) (sp == '0) |-> !dec);
    p_incdec_excl_r4: assert property (@(posedge clk) disable iff (rst) !(inc && dec));
endmodule

// File: rtl/cirq_ctl.sv
module cirq_ctl
    import cirq_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          DEPTH     = 16,
    parameter int          SPW       = $clog2(DEPTH + 1),
    parameter int          IE_BIT    = 7,
    parameter int unsigned VEC_FAULT = 32'h0010,
    parameter int unsigned VEC_EXT   = 32'h0020,
    parameter int unsigned VEC_SWI   = 32'h0030
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           call_req,
    input  logic           ret_req,
    input  logic           reti_req,
    input  logic [DW-1:0]  call_target,
    input  logic [DW-1:0]  next_pc,
    input  logic           at_boundary,
    input  logic [DW-1:0]  psw_in,
    input  logic           fault_irq,
    input  logic           ext_irq,
    input  logic           swi_irq,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_we,
    output logic           mem_re,
    output logic [SPW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           pc_load,
    output logic [DW-1:0]  pc_out,
    output logic           psw_load,
    output logic [DW-1:0]  psw_out,
    output logic [2:0]     irq_ack,
    output logic [SPW-1:0] sp,
    output logic           busy
);
    localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;
    localparam logic [DW-1:0] V_FAULT = DW'(VEC_FAULT);
    localparam logic [DW-1:0] V_EXT   = DW'(VEC_EXT);
    localparam logic [DW-1:0] V_SWI   = DW'(VEC_SWI);

    ctl_state_e state_q, state_d;
    irq_class_e cls_q, cls_d, arb_cls;
    logic [DW-1:0] ret_pc_q, ret_pc_d, tgt_q, tgt_d, psw_q, psw_d;
    logic sp_inc, sp_dec, room1, room2, has1, has2, irq_take;
    irq_lines_t lines;

    function automatic logic [DW-1:0] vec_of(irq_class_e c);
        case (c)
            CL_EXT:  return V_EXT;
            CL_SWI:  return V_SWI;
            default: return V_FAULT;
        endcase
    endfunction

    assign lines = '{fault: fault_irq, ext: ext_irq, swi: swi_irq};

    cirq_arb u_arb (
        .lines  (lines),
        .enable (at_boundary && psw_in[IE_BIT]),
        .take   (irq_take),
        .cls    (arb_cls)
    );

    cirq_sptr #(.DEPTH(DEPTH), .SPW(SPW)) u_sptr (
        .clk   (clk),
        .rst   (rst),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp),
        .room1 (room1),
        .room2 (room2),
        .has1  (has1),
        .has2  (has2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cls_q    <= CL_NONE;
            ret_pc_q <= '0;
            tgt_q    <= '0;
            psw_q    <= '0;
        end else begin
            state_q  <= state_d;
            cls_q    <= cls_d;
            ret_pc_q <= ret_pc_d;
            tgt_q    <= tgt_d;
            psw_q    <= psw_d;
        end
    end

    // Next-state: strobes first, then a sampled interrupt.
    always_comb begin
        state_d  = state_q;
        cls_d    = cls_q;
        ret_pc_d = ret_pc_q;
        tgt_d    = tgt_q;
        psw_d    = psw_q;
        case (state_q)
            ST_IDLE: begin
                if (call_req) begin
                    ret_pc_d = next_pc;
                    tgt_d    = call_target;
                    psw_d    = psw_in;
                    state_d  = room1 ? ST_CALL : ST_FAULT;
                end else if (ret_req) begin
                    psw_d   = psw_in;
                    state_d = has1 ? ST_RET_RD : ST_FAULT;
                end else if (reti_req) begin
                    psw_d   = psw_in;
                    state_d = has2 ? ST_RTI_PSW : ST_FAULT;
                end else if (irq_take) begin
                    ret_pc_d = next_pc;
                    psw_d    = psw_in;
                    cls_d    = arb_cls;
                    state_d  = room2 ? ST_IRQ_PC : ST_FAULT;
                end
            end
            ST_RET_RD:  state_d = ST_RET_WB;
            ST_IRQ_PC:  state_d = ST_IRQ_PSW;
            ST_RTI_PSW: state_d = ST_RTI_PC;
            ST_RTI_PC:  state_d = ST_RTI_WB;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs per state.
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = '0;
        pc_load   = 1'b0;
        pc_out    = '0;
        psw_load  = 1'b0;
        psw_out   = '0;
        irq_ack   = 3'b000;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        case (state_q)
            ST_CALL: begin
                mem_we    = 1'b1;
                mem_wdata = ret_pc_q;
                pc_load   = 1'b1;
                pc_out    = tgt_q;
                sp_inc    = 1'b1;
            end
            ST_RET_RD, ST_RTI_PSW: begin
                mem_re   = 1'b1;
                mem_addr = sp - SPW'(1);
                sp_dec   = 1'b1;
            end
            ST_RET_WB, ST_RTI_WB: begin
                pc_load = 1'b1;
                pc_out  = mem_rdata;
            end
            ST_IRQ_PC: begin
                mem_we    = 1'b1;
                mem_wdata = ret_pc_q;
                sp_inc    = 1'b1;
            end
            ST_IRQ_PSW: begin
                mem_we    = 1'b1;
                mem_wdata = psw_q;
                sp_inc    = 1'b1;
                pc_load   = 1'b1;
                pc_out    = vec_of(cls_q);
                psw_load  = 1'b1;
                psw_out   = psw_q & ~IE_MASK;
                irq_ack   = class_ack(cls_q);
            end
            ST_RTI_PC: begin
                psw_load = 1'b1;
                psw_out  = mem_rdata;
                mem_re   = 1'b1;
                mem_addr = sp - SPW'(1);
                sp_dec   = 1'b1;
            end
            ST_FAULT: begin
                pc_load  = 1'b1;
                pc_out   = V_FAULT;
                psw_load = 1'b1;
                psw_out  = psw_q & ~IE_MASK;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    p_call_push_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CALL) |=> (sp == $past(sp) + SPW'(1)));
    p_ret_pop_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RET_RD) |=> (sp == $past(sp) - SPW'(1)) && pc_load);
    p_ack_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(irq_ack));
    p_entry_ie_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_ack != 3'b000) |-> psw_load && !psw_out[IE_BIT]);
    p_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !call_req && !ret_req && !reti_req && (!at_boundary || !psw_in[IE_BIT]))
        |=> !busy);
    p_fault_nopush_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT) |-> !mem_we && !mem_re);
    p_fault_sp_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT) |=> $stable(sp));
    p_rw_excl_r4: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re));
endmodule

// File: tb/cirq_ctl_bench.sv
module cirq_ctl_bench;
    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam int SPW = $clog2(DEPTH + 1);
    localparam logic [15:0] VF = 16'h0010;
    localparam logic [15:0] VE = 16'h0020;
    localparam logic [15:0] VS = 16'h0030;
    localparam logic [15:0] PSW_ON  = 16'h00A5;
    localparam logic [15:0] PSW_OFF = 16'h0025;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic call_req = 0, ret_req = 0, reti_req = 0;
    logic [DW-1:0] call_target = '0, next_pc = '0, psw_in = PSW_ON;
    logic at_boundary = 0, fault_irq = 0, ext_irq = 0, swi_irq = 0;
    logic [DW-1:0] mem_rdata;
    logic mem_we, mem_re, pc_load, psw_load, busy;
    logic [SPW-1:0] mem_addr, sp;
    logic [DW-1:0] mem_wdata, pc_out, psw_out;
    logic [2:0] irq_ack;
    logic [DW-1:0] bmem [DEPTH];
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_we) bmem[mem_addr[3:0]] <= mem_wdata;
        mem_rdata <= bmem[mem_addr[3:0]];
    end

    cirq_ctl u_cirq_ctl (
        .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req), .reti_req(reti_req),
        .call_target(call_target), .next_pc(next_pc), .at_boundary(at_boundary),
        .psw_in(psw_in), .fault_irq(fault_irq), .ext_irq(ext_irq), .swi_irq(swi_irq),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_out(pc_out), .psw_load(psw_load),
        .psw_out(psw_out), .irq_ack(irq_ack), .sp(sp), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic fault_path(input string tag, input int sp0);
        chk({tag, " no write"}, mem_we, 0);
        chk({tag, " no read"}, mem_re, 0);
        chk({tag, " pc_load"}, pc_load, 1);
        chk({tag, " fault vector"}, pc_out, VF);
        chk({tag, " psw_load"}, psw_load, 1);
        chk({tag, " ie cleared"}, psw_out, psw_in & ~16'h0080);
        @(negedge clk);
        chk({tag, " sp unchanged"}, sp, sp0);
        chk({tag, " idle"}, busy, 0);
    endtask

    task automatic do_call(input logic [15:0] tgt, input logic [15:0] rpc);
        int sp0 = int'(sp);
        call_req = 1; call_target = tgt; next_pc = rpc;
        @(negedge clk);
        call_req = 0;
        if (sp0 < DEPTH) begin
            chk("R2 write strobe", mem_we, 1);
            chk("R2 write addr", mem_addr, sp0);
            chk("R2 return pc", mem_wdata, rpc);
            chk("R2 pc_load", pc_load, 1);
            chk("R2 target", pc_out, tgt);
            chk("R11 busy", busy, 1);
            @(negedge clk);
            chk("R2 sp inc", sp, sp0 + 1);
        end else begin
            fault_path("R9 call overflow", sp0);
        end
    endtask

    task automatic do_ret(input logic [15:0] exp_pc);
        int sp0 = int'(sp);
        ret_req = 1;
        @(negedge clk);
        ret_req = 0;
        if (sp0 > 0) begin
            chk("R3 read strobe", mem_re, 1);
            chk("R3 read addr", mem_addr, sp0 - 1);
            chk("R3 no early load", pc_load, 0);
            @(negedge clk);
            chk("R3 pc_load", pc_load, 1);
            chk("R3 popped pc", pc_out, exp_pc);
            chk("R3 sp dec", sp, sp0 - 1);
            @(negedge clk);
        end else begin
            fault_path("R10 ret underflow", sp0);
        end
    endtask

    task automatic do_irq(input logic f, input logic e, input logic s, input logic [15:0] rpc);
        int sp0 = int'(sp);
        logic [15:0] vec = f ? VF : (e ? VE : VS);
        logic [2:0] ack = f ? 3'b001 : (e ? 3'b010 : 3'b100);
        at_boundary = 1; fault_irq = f; ext_irq = e; swi_irq = s; next_pc = rpc;
        @(negedge clk);
        at_boundary = 0; fault_irq = 0; ext_irq = 0; swi_irq = 0;
        if (sp0 + 2 <= DEPTH) begin
            chk("R4 pc push strobe", mem_we, 1);
            chk("R4 pc push addr", mem_addr, sp0);
            chk("R4 pc push data", mem_wdata, rpc);
            chk("R4 no early load", pc_load, 0);
            @(negedge clk);
            chk("R4 psw push addr", mem_addr, sp0 + 1);
            chk("R4 psw push data", mem_wdata, psw_in);
            chk("R5 vector", pc_out, vec);
            chk("R5 pc_load", pc_load, 1);
            chk("R5 ack", irq_ack, ack);
            chk("R6 psw_load", psw_load, 1);
            chk("R6 ie cleared", psw_out, psw_in & ~16'h0080);
            @(negedge clk);
            chk("R4 sp plus two", sp, sp0 + 2);
        end else begin
            chk("R9 no ack", irq_ack, 0);
            fault_path("R9 irq overflow", sp0);
        end
    endtask

    task automatic do_reti(input logic [15:0] exp_psw, input logic [15:0] exp_pc);
        int sp0 = int'(sp);
        reti_req = 1;
        @(negedge clk);
        reti_req = 0;
        if (sp0 >= 2) begin
            chk("R8 psw read", mem_re, 1);
            chk("R8 psw addr", mem_addr, sp0 - 1);
            @(negedge clk);
            chk("R8 psw_load", psw_load, 1);
            chk("R8 psw restored", psw_out, exp_psw);
            chk("R8 pc addr", mem_addr, sp0 - 2);
            @(negedge clk);
            chk("R8 pc restored", pc_out, exp_pc);
            chk("R8 pc_load", pc_load, 1);
            chk("R8 sp minus two", sp, sp0 - 2);
            @(negedge clk);
        end else begin
            fault_path("R10 reti underflow", sp0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sp", sp, 0);
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {mem_we, mem_re, pc_load, psw_load}, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 idle after reset", {busy, mem_we, mem_re, pc_load, psw_load}, 0);

        for (int i = 0; i < DEPTH; i++) do_call(16'h1000 + 16'(i * 17), 16'h2000 + 16'(i * 3));
        do_call(16'h1FFF, 16'h2FFF);
        for (int i = DEPTH - 1; i >= 0; i--) do_ret(16'h2000 + 16'(i * 3));
        do_ret(16'h0000);
        do_reti(16'h0000, 16'h0000);
        do_call(16'h1234, 16'h4321);
        do_reti(16'h0000, 16'h0000);
        do_ret(16'h4321);

        for (int m = 1; m < 8; m++) begin
            do_irq(m[2], m[1], m[0], 16'h3000 + 16'(m));
            do_reti(PSW_ON, 16'h3000 + 16'(m));
        end

        psw_in = PSW_OFF; at_boundary = 1; fault_irq = 1; ext_irq = 1; swi_irq = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 masked by ie", {busy, mem_we, pc_load, psw_load}, 0);
        end
        psw_in = PSW_ON; at_boundary = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 off boundary", {busy, mem_we, pc_load, psw_load}, 0);
        end
        chk("R7 sp untouched", sp, 0);
        fault_irq = 0; ext_irq = 0; swi_irq = 0;

        for (int i = 0; i < DEPTH - 1; i++) do_call(16'h0100 + 16'(i), 16'h0500 + 16'(i));
        do_irq(1'b0, 1'b1, 1'b0, 16'h0777);
        for (int i = DEPTH - 2; i >= 0; i--) do_ret(16'h0500 + 16'(i));

        @(negedge clk);
        call_req = 1; call_target = 16'h0ABC; next_pc = 16'h0DEF;
        at_boundary = 1; ext_irq = 1;
        @(negedge clk);
        call_req = 0; at_boundary = 0; ext_irq = 0;
        chk("R11 call wins data", mem_wdata, 16'h0DEF);
        chk("R11 call wins pc", pc_out, 16'h0ABC);
        chk("R11 no ack", irq_ack, 0);
        @(negedge clk);
        chk("R11 sp one", sp, 1);
        do_ret(16'h0DEF);

        summary();
    end
endmodule